// File: doc/BRIEF.md
# Handshaked Serial Byte Transmitter

This block puts one byte at a time onto an asynchronous serial line. A local controller presents a byte on a parallel input and raises a request. The block captures the byte on the rising request and sends a frame: one low start bit, the eight data bits starting from bit 0, and two high stop bits. It then raises an acknowledge and holds it until the controller lowers the request. This completes a four-phase request/acknowledge exchange, after which the block waits for the next rising request.

The block runs from a clock at eight times the bit rate, so every bit on the line lasts exactly eight clock cycles. For 9600 baud that clock is 76.8 kHz. A synchronous clear returns the block to its resting state at any time. All eight data bits are sent exactly as given, including the top bit, which is zero for ASCII characters.

Top module: `serial_tx_hs`

## Requirements
- R1: After clear and whenever no frame is in progress, the serial line `txd` is 1 and `ack` is 0 unless the handshake is in its acknowledge phase.
- R2: A rising edge of `req` seen at a clock edge while idle starts a frame. `txd` is 0 for the 8 cycles that follow that edge (the start bit).
- R3: The 8 data bits follow the start bit with bit 0 first and bit 7 last. Each bit is held on `txd` for exactly 8 cycles, and bit 7 is sent unchanged whatever its value.
- R4: Two stop bits at 1 follow the data bits, each lasting 8 cycles, so a frame occupies 88 cycles.
- R5: `din` is captured at the edge that accepts the request, and changes on `din` during the frame do not alter the bits sent.
- R6: `ack` rises at the clock edge 88 cycles after the accepting edge. It stays at 1, with `txd` at 1, for as long as `req` stays high.
- R7: At the first clock edge where `req` is seen low during the acknowledge phase, `ack` falls and the block is idle again.
- R8: A `req` that is still high while `ack` is high never starts a second frame. A new frame needs `req` to fall and rise again.
- R9: With `clr` high at a clock edge, `txd` is 1 and `ack` is 0 after that edge, even in the middle of a frame. A `req` that is already high at clear must fall and rise before a frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at eight times the bit rate |
| clr | input | 1 | Synchronous clear, active high |
| req | input | 1 | Request from the local controller |
| din | input | 8 | Byte to send, captured on accepted request |
| ack | output | 1 | Acknowledge, high from frame end until request falls |
| txd | output | 1 | Serial output line, resting at 1 |

## Verification
Each result is tied to the edge that accepts the request. Call that edge E0. Bit k of the frame (0 for start, 1 to 8 for data, 9 and 10 for stop) is on the line from E0+8k to E0+8k+8, and the bench samples it at a falling edge in the middle of that window, four cycles into the bit. `ack` must still be low at the falling edge after E0+87 and high at the falling edge after E0+88. It falls after the first edge that sees the request low. A clear acts on the very next edge, and the bench checks both outputs at the following falling edge. Inputs change only at falling edges, so no check depends on the order in which events occur at a rising edge.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_ACK  = 2'd2
  } stx_state_e;

  // total number of bit slots in one frame
  function automatic int frame_slots(input int data_w, input int stop_bits);
    return 1 + data_w + stop_bits;
  endfunction

  // width of a counter able to hold values 0 .. n-1 (at least 1 bit)
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
  parameter int OVERSAMPLE = 8
) (
  input  logic clk,
  input  logic clr,
  input  logic restart,
  input  logic run,
  output logic bit_end
);
  import stx_pkg::*;

  localparam int TICK_W = cnt_width(OVERSAMPLE);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);

  logic [TICK_W-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (clr || restart) begin
      tick_q <= '0;
    end else if (run) begin
      if (tick_q == TICK_LAST) tick_q <= '0;
      else                     tick_q <= tick_q + 1'b1;
    end
  end

  assign bit_end = run && (tick_q == TICK_LAST);

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  output logic              line
);
  import stx_pkg::*;

  localparam int SLOTS = frame_slots(DATA_W, STOP_BITS);

  logic [SLOTS-1:0] frame_q;
  logic [SLOTS-1:0] frame_init;

  // slot 0 is the start bit, then data from bit 0 upward, then stop bits
  always_comb begin
    frame_init = '1;
    frame_init[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      frame_init[1 + i] = data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (clr)        frame_q <= '1;
    else if (load)  frame_q <= frame_init;
    else if (shift) frame_q <= {1'b1, frame_q[SLOTS-1:1]};
  end

  assign line = frame_q[0];

endmodule

// File: rtl/stx_ctrl.sv
module stx_ctrl #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic req,
  input  logic bit_end,
  output logic start_evt,
  output logic busy,
  output logic frame_done,
  output logic ack
);
  import stx_pkg::*;

  localparam int SLOTS = frame_slots(DATA_W, STOP_BITS);
  localparam int IDX_W = cnt_width(SLOTS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

  stx_state_e        state_q, state_d;
  logic              req_prev_q;
  logic [IDX_W-1:0]  slot_q;

  assign start_evt  = (state_q == ST_IDLE) && req && !req_prev_q;
  assign busy       = (state_q == ST_SEND);
  assign frame_done = busy && bit_end && (slot_q == IDX_LAST);
  assign ack        = (state_q == ST_ACK);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_evt)  state_d = ST_SEND;
      ST_SEND: if (frame_done) state_d = ST_ACK;
      ST_ACK:  if (!req)       state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q    <= ST_IDLE;
      req_prev_q <= 1'b1;
      slot_q     <= '0;
    end else begin
      state_q    <= state_d;
      req_prev_q <= req;
      if (start_evt)                slot_q <= '0;
      else if (busy && bit_end)     slot_q <= slot_q + 1'b1;
    end
  end

endmodule

// File: rtl/serial_tx_hs.sv
module serial_tx_hs #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 8,
  parameter int STOP_BITS  = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              req,
  input  logic [DATA_W-1:0] din,
  output logic              ack,
  output logic              txd
);

  // internal events brought out as named wires
  logic start_evt;
  logic busy;
  logic bit_end;
  logic frame_done;

  stx_ctrl #(
    .DATA_W    (DATA_W),
    .STOP_BITS (STOP_BITS)
  ) i_ctrl (
    .clk        (clk),
    .clr        (clr),
    .req        (req),
    .bit_end    (bit_end),
    .start_evt  (start_evt),
    .busy       (busy),
    .frame_done (frame_done),
    .ack        (ack)
  );

  stx_bit_timer #(
    .OVERSAMPLE (OVERSAMPLE)
  ) i_timer (
    .clk     (clk),
    .clr     (clr),
    .restart (start_evt),
    .run     (busy),
    .bit_end (bit_end)
  );

  stx_shifter #(
    .DATA_W    (DATA_W),
    .STOP_BITS (STOP_BITS)
  ) i_shift (
    .clk   (clk),
    .clr   (clr),
    .load  (start_evt),
    .shift (bit_end),
    .data  (din),
    .line  (txd)
  );

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
  input logic clk,
  input logic clr,
  input logic req,
  input logic ack,
  input logic txd,
  input logic busy,
  input logic bit_end,
  input logic start_evt,
  input logic frame_done
);

  // R1: line rests high outside a frame
  assert_idle_line_R1: assert property (@(posedge clk) disable iff (clr)
    !busy |-> txd);

  // R2: accepted request puts the start bit on the line
  assert_start_low_R2: assert property (@(posedge clk) disable iff (clr)
    start_evt |=> !txd);

  // R3: the line only changes at a bit boundary while sending
  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (clr)
    (busy && !bit_end) |=> $stable(txd));

  // R4: the last slot of a frame is a stop bit
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (clr)
    frame_done |-> txd);

  // R6: acknowledge held while request is high
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (clr)
    (ack && req) |=> ack);

  // R7: acknowledge drops once request is low
  assert_ack_drop_R7: assert property (@(posedge clk) disable iff (clr)
    (ack && !req) |=> !ack);

  // R8: no new frame while the request stays high in acknowledge
  assert_no_rearm_R8: assert property (@(posedge clk) disable iff (clr)
    (ack && req) |=> !busy);

  // R9: clear forces the resting outputs on the next edge
  assert_clear_idle_R9: assert property (@(posedge clk)
    clr |=> (txd && !ack));

endmodule

bind serial_tx_hs stx_checker i_chk (
  .clk        (clk),
  .clr        (clr),
  .req        (req),
  .ack        (ack),
  .txd        (txd),
  .busy       (busy),
  .bit_end    (bit_end),
  .start_evt  (start_evt),
  .frame_done (frame_done)
);

// File: tb/test_serial_tx_hs.sv
`timescale 1ns/1ps
module test_serial_tx_hs;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       req = 1'b0;
  logic [7:0] din = 8'h00;
  logic       ack;
  logic       txd;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  serial_tx_hs i_serial_tx_hs (
    .clk (clk), .clr (clr), .req (req), .din (din), .ack (ack), .txd (txd)
  );

  // expected line value for frame slot k of byte b
  function automatic logic slot_val(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    return 1'b1;
  endfunction

  task automatic check(input string req_tag, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req_tag, what, act, exp);
    end
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // send one frame; at entry we are at a falling edge, req low
  task automatic send_frame(input logic [7:0] b, input int hold, input bit scramble);
    req = 1'b1;
    din = b;
    repeat (5) @(negedge clk);          // middle of start slot
    for (int k = 0; k < 11; k++) begin
      if (scramble) din = 8'($urandom);  // R5: must not matter
      if (k == 0)      check("R2", "start bit", txd, slot_val(b, k));
      else if (k <= 8) check("R3", $sformatf("data bit %0d of %h", k-1, b), txd, slot_val(b, k));
      else             check("R4", "stop bit", txd, slot_val(b, k));
      if (scramble && k >= 1 && k <= 8)
        check("R5", "latched data", txd, slot_val(b, k));
      if (k < 10) repeat (8) @(negedge clk);
    end
    repeat (3) @(negedge clk);          // after edge E0+87
    check("R6", "ack before frame end", ack, 1'b0);
    @(negedge clk);                     // after edge E0+88
    check("R6", "ack at frame end", ack, 1'b1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R8", "ack held, no new frame", ack, 1'b1);
      check("R8", "line high while ack", txd, 1'b1);
    end
    req = 1'b0;
    @(negedge clk);
    check("R7", "ack falls", ack, 1'b0);
    check("R1", "idle line", txd, 1'b1);
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    check("R1", "reset line", txd, 1'b1);
    check("R1", "reset ack", ack, 1'b0);

    // directed corner bytes
    send_frame(8'h00, 0, 1'b0);
    send_frame(8'hFF, 3, 1'b0);
    send_frame(8'h80, 1, 1'b0);         // R3: top bit sent as given
    send_frame(8'h55, 5, 1'b1);

    // constrained random bytes, holds and gaps
    for (int n = 0; n < 8; n++) begin
      int gap;
      gap = int'($urandom_range(0, 6));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check("R1", "idle gap", txd, 1'b1);
      end
      send_frame(8'($urandom), int'($urandom_range(0, 20)), n[0]);
    end

    // R8: request held high after ack must not restart
    req = 1'b1; din = 8'h3C;
    repeat (100) @(negedge clk);
    check("R6", "ack up with req held", ack, 1'b1);
    repeat (50) @(negedge clk);
    check("R8", "still acked, line high", txd & ack, 1'b1);
    req = 1'b0;
    @(negedge clk);
    repeat (20) @(negedge clk);
    check("R8", "no second frame", txd, 1'b1);

    // R9: clear in the middle of a frame
    req = 1'b1; din = 8'h00;
    repeat (20) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    check("R9", "clear line", txd, 1'b1);
    check("R9", "clear ack", ack, 1'b0);
    clr = 1'b0;
    repeat (30) @(negedge clk);
    check("R9", "held req after clear no frame", txd, 1'b1);
    req = 1'b0;
    @(negedge clk);
    send_frame(8'hA7, 2, 1'b0);

    // R9: clear during acknowledge
    req = 1'b1; din = 8'h41;
    repeat (95) @(negedge clk);
    check("R6", "ack before clear", ack, 1'b1);
    clr = 1'b1;
    @(negedge clk);
    check("R9", "clear drops ack", ack, 1'b0);
    clr = 1'b0; req = 1'b0;
    @(negedge clk);
    send_frame(8'h0D, 0, 1'b1);

    summary();
  end

endmodule